// File: doc/BRIEF.md
# Hysteretic Power-Good Monitor

This block decides, per supply channel, whether a regulated output may be declared healthy. Each channel takes a stream of digitised output-voltage codes together with a target code. It raises a power-good flag only after the output has stayed clearly above a high threshold for a qualification time. It drops the flag only after the output has stayed below a lower threshold for a separate, much shorter qualification time. The gap between the two thresholds forms a hysteresis band. A sample inside that band never qualifies either transition.

Each channel also drives an active-low reset output. That output holds downstream logic in reset whenever its channel is not good. Channel 1 has fixed qualification times set by parameters. Channel 2 derives both of its times from one configuration input, scaled linearly. On both channels the exit time has a floor, so that short glitches cannot trip it.

The sample inputs are valid/ready streams. A channel's ready follows its enable: an enabled channel takes one sample on every clock and never applies back-pressure. A disabled channel refuses all samples. The latest accepted comparison result stays in force until the next sample arrives. Timing is counted in clock cycles, not in samples.

Top module: `power_good_mon`

## Requirements
- R1: A sample counts as high when code*100 > target*94, and as low when code*100 < target*90. A sample that is neither high nor low lies in the band and qualifies no transition. For example, with target 500, code 471 is high, code 470 is in the band, code 450 is in the band, and code 449 is low.
- R2: From the not-good state, power-good rises after the clock edge at which the high condition has held on L_entry+1 consecutive edges. The count includes the edge that accepted the high sample.
- R3: From the good state, power-good falls after the clock edge at which the low condition has held on L_exit+1 consecutive edges. The count includes the edge that accepted the low sample.
- R4: An accepted sample that breaks the condition being qualified restarts that qualification from zero. A band sample breaks either condition.
- R5: Each reset output is low while its channel is not good, and high while its channel is good.
- R6: Channel 1 uses L_entry = ENTRY1_CYC and L_exit = max(EXIT1_CYC, EXIT_MIN_CYC).
- R7: Channel 2 uses L_entry = cfg_scale*ENTRY2_UNIT and L_exit = max(cfg_scale*EXIT2_UNIT, EXIT_MIN_CYC). A cfg_scale of 0 gives immediate entry, while the exit time stays at the floor.
- R8: After reset, or while a channel is disabled, that channel is not good. Its timer and its latched comparison result are cleared, so re-enabling it does not restore the good state without new samples.
- R9: Each channel's ready equals its enable. A sample offered while ready is low is ignored.
- R10: The comparison result of the last accepted sample persists between strobes, and qualification keeps counting without new samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en1 | input | 1 | Channel 1 enable |
| s1_valid | input | 1 | Channel 1 sample valid |
| s1_ready | output | 1 | Channel 1 sample ready (equals en1) |
| s1_code | input | CODE_W | Channel 1 output-voltage code |
| tgt1 | input | CODE_W | Channel 1 target code |
| pgood1 | output | 1 | Channel 1 power-good flag |
| rst1_n | output | 1 | Channel 1 active-low reset output |
| en2 | input | 1 | Channel 2 enable |
| s2_valid | input | 1 | Channel 2 sample valid |
| s2_ready | output | 1 | Channel 2 sample ready (equals en2) |
| s2_code | input | CODE_W | Channel 2 output-voltage code |
| tgt2 | input | CODE_W | Channel 2 target code |
| cfg_scale | input | SCALE_W | Channel 2 delay scale factor |
| pgood2 | output | 1 | Channel 2 power-good flag |
| rst2_n | output | 1 | Channel 2 active-low reset output |

## Verification
The bench shrinks the millisecond defaults so that every transition fits in a short run. It sets ENTRY1_CYC=20, EXIT1_CYC=8, ENTRY2_UNIT=30, EXIT2_UNIT=2 and EXIT_MIN_CYC=6, with a 4-bit cfg_scale. With these values the channel 2 exit is clamped to the floor at scale 1 and unclamped at scale 5. Scale 0 exercises immediate entry. The exact rise and fall cycle can be checked on both channels, along with restarts caused by band samples placed partway into a qualification window.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef struct packed {
    logic above;
    logic below;
  } pgm_cmp_t;
endpackage

// File: rtl/pgm_cmp.sv
module pgm_cmp #(
  parameter int CODE_W    = 10,
  parameter int ENTRY_PCT = 94,
  parameter int EXIT_PCT  = 90
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] tgt,
  output pgm_pkg::pgm_cmp_t res
);
  localparam int PW = CODE_W + 7;

  logic [PW-1:0] code_x100, tgt_hi, tgt_lo;

  always_comb begin
    code_x100 = PW'(code) * PW'(100);
    tgt_hi    = PW'(tgt) * PW'(ENTRY_PCT);
    tgt_lo    = PW'(tgt) * PW'(EXIT_PCT);
    res.above = code_x100 > tgt_hi;
    res.below = code_x100 < tgt_lo;
  end
endmodule

// File: rtl/pgm_limits.sv
module pgm_limits #(
  parameter int SCALE_W      = 8,
  parameter int CNT_W        = 32,
  parameter int ENTRY_UNIT   = 5000000,
  parameter int EXIT_UNIT    = 625,
  parameter int EXIT_MIN_CYC = 2500
) (
  input  logic [SCALE_W-1:0] scale,
  output logic [CNT_W-1:0]   entry_lim,
  output logic [CNT_W-1:0]   exit_lim
);
  logic [CNT_W-1:0] exit_raw;

  assign entry_lim = CNT_W'(scale) * CNT_W'(ENTRY_UNIT);
  assign exit_raw  = CNT_W'(scale) * CNT_W'(EXIT_UNIT);

  generate
    if (EXIT_MIN_CYC > 0) begin : g_floor
      assign exit_lim = (exit_raw < CNT_W'(EXIT_MIN_CYC)) ? CNT_W'(EXIT_MIN_CYC) : exit_raw;
    end else begin : g_raw
      assign exit_lim = exit_raw;
    end
  endgenerate
endmodule

// File: rtl/pgm_qual.sv
module pgm_qual #(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               valid,
  input  pgm_pkg::pgm_cmp_t  cmp,
  input  logic [CNT_W-1:0]   entry_lim,
  input  logic [CNT_W-1:0]   exit_lim,
  output logic               good
);
  logic             hi_q, lo_q;
  logic             qual_hi, qual_lo;
  logic [CNT_W-1:0] cnt;

  // A fresh sample decides this edge; otherwise the last accepted result holds.
  assign qual_hi = valid ? cmp.above : hi_q;
  assign qual_lo = valid ? cmp.below : lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      cnt  <= '0;
      good <= 1'b0;
    end else if (!en) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      cnt  <= '0;
      good <= 1'b0;
    end else begin
      if (valid) begin
        hi_q <= cmp.above;
        lo_q <= cmp.below;
      end
      if (!good) begin
        if (qual_hi) begin
          if (cnt >= entry_lim) begin
            good <= 1'b1;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end else begin
        if (qual_lo) begin
          if (cnt >= exit_lim) begin
            good <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/power_good_mon.sv
module power_good_mon #(
  parameter int CODE_W       = 10,
  parameter int CNT_W        = 32,
  parameter int SCALE_W      = 8,
  parameter int ENTRY1_CYC   = 500000,
  parameter int EXIT1_CYC    = 6250,
  parameter int ENTRY2_UNIT  = 5000000,
  parameter int EXIT2_UNIT   = 625,
  parameter int EXIT_MIN_CYC = 2500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en1,
  input  logic               s1_valid,
  output logic               s1_ready,
  input  logic [CODE_W-1:0]  s1_code,
  input  logic [CODE_W-1:0]  tgt1,
  output logic               pgood1,
  output logic               rst1_n,
  input  logic               en2,
  input  logic               s2_valid,
  output logic               s2_ready,
  input  logic [CODE_W-1:0]  s2_code,
  input  logic [CODE_W-1:0]  tgt2,
  input  logic [SCALE_W-1:0] cfg_scale,
  output logic               pgood2,
  output logic               rst2_n
);
  import pgm_pkg::*;

  localparam logic [CNT_W-1:0] ENTRY1_LIM = CNT_W'(ENTRY1_CYC);
  localparam logic [CNT_W-1:0] EXIT1_LIM  =
    (EXIT1_CYC < EXIT_MIN_CYC) ? CNT_W'(EXIT_MIN_CYC) : CNT_W'(EXIT1_CYC);

  pgm_cmp_t         cmp1, cmp2;
  logic [CNT_W-1:0] entry2_lim, exit2_lim;

  assign s1_ready = en1;
  assign s2_ready = en2;

  pgm_cmp #(.CODE_W(CODE_W)) u_cmp1 (.code(s1_code), .tgt(tgt1), .res(cmp1));
  pgm_cmp #(.CODE_W(CODE_W)) u_cmp2 (.code(s2_code), .tgt(tgt2), .res(cmp2));

  pgm_limits #(
    .SCALE_W(SCALE_W), .CNT_W(CNT_W), .ENTRY_UNIT(ENTRY2_UNIT),
    .EXIT_UNIT(EXIT2_UNIT), .EXIT_MIN_CYC(EXIT_MIN_CYC)
  ) u_lim2 (
    .scale(cfg_scale), .entry_lim(entry2_lim), .exit_lim(exit2_lim)
  );

  pgm_qual #(.CNT_W(CNT_W)) u_q1 (
    .clk(clk), .rst_n(rst_n), .en(en1), .valid(s1_valid & s1_ready),
    .cmp(cmp1), .entry_lim(ENTRY1_LIM), .exit_lim(EXIT1_LIM), .good(pgood1)
  );

  pgm_qual #(.CNT_W(CNT_W)) u_q2 (
    .clk(clk), .rst_n(rst_n), .en(en2), .valid(s2_valid & s2_ready),
    .cmp(cmp2), .entry_lim(entry2_lim), .exit_lim(exit2_lim), .good(pgood2)
  );

  assign rst1_n = pgood1;
  assign rst2_n = pgood2;
endmodule

// File: rtl/pgm_chk.sv
module pgm_chk #(
  parameter int CODE_W       = 10,
  parameter int SCALE_W      = 8,
  parameter int ENTRY1_CYC   = 500000,
  parameter int EXIT1_CYC    = 6250,
  parameter int EXIT_MIN_CYC = 2500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en1,
  input logic              s1_valid,
  input logic [CODE_W-1:0] s1_code,
  input logic [CODE_W-1:0] tgt1,
  input logic              pgood1,
  input logic              en2,
  input logic              s2_valid,
  input logic [CODE_W-1:0] s2_code,
  input logic [CODE_W-1:0] tgt2,
  input logic              pgood2
);
  localparam int EXIT1_EFF = (EXIT1_CYC < EXIT_MIN_CYC) ? EXIT_MIN_CYC : EXIT1_CYC;

  logic hi1_l, lo1_l, lo2_l;
  int   run_hi1, run_lo1, run_lo2;
  logic a1, b1, b2, q_hi1, q_lo1, q_lo2;

  always_comb begin
    a1    = (int'(s1_code) * 100) > (int'(tgt1) * 94);
    b1    = (int'(s1_code) * 100) < (int'(tgt1) * 90);
    b2    = (int'(s2_code) * 100) < (int'(tgt2) * 90);
    q_hi1 = s1_valid ? a1 : hi1_l;
    q_lo1 = s1_valid ? b1 : lo1_l;
    q_lo2 = s2_valid ? b2 : lo2_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi1_l <= 1'b0; lo1_l <= 1'b0; lo2_l <= 1'b0;
      run_hi1 <= 0; run_lo1 <= 0; run_lo2 <= 0;
    end else begin
      if (!en1) begin
        hi1_l <= 1'b0; lo1_l <= 1'b0; run_hi1 <= 0; run_lo1 <= 0;
      end else begin
        if (s1_valid) begin hi1_l <= a1; lo1_l <= b1; end
        run_hi1 <= q_hi1 ? ((run_hi1 < 32'h3fffffff) ? run_hi1 + 1 : run_hi1) : 0;
        run_lo1 <= q_lo1 ? ((run_lo1 < 32'h3fffffff) ? run_lo1 + 1 : run_lo1) : 0;
      end
      if (!en2) begin
        lo2_l <= 1'b0; run_lo2 <= 0;
      end else begin
        if (s2_valid) lo2_l <= b2;
        run_lo2 <= q_lo2 ? ((run_lo2 < 32'h3fffffff) ? run_lo2 + 1 : run_lo2) : 0;
      end
    end
  end

  AST_ENTRY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood1) |-> run_hi1 > ENTRY1_CYC); // R2
  AST_EXIT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pgood1) && $past(en1)) |-> run_lo1 > EXIT1_EFF); // R3
  AST_EXIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pgood2) && $past(en2)) |-> run_lo2 > EXIT_MIN_CYC); // R7
  AST_OFF_CLEARS1: assert property (@(posedge clk) disable iff (!rst_n)
    !en1 |=> !pgood1); // R8
  AST_OFF_CLEARS2: assert property (@(posedge clk) disable iff (!rst_n)
    !en2 |=> !pgood2); // R8
endmodule

bind power_good_mon pgm_chk #(
  .CODE_W(CODE_W), .SCALE_W(SCALE_W), .ENTRY1_CYC(ENTRY1_CYC),
  .EXIT1_CYC(EXIT1_CYC), .EXIT_MIN_CYC(EXIT_MIN_CYC)
) u_chk (.*);

// File: tb/power_good_mon_tb.sv
module power_good_mon_tb;
  localparam int CODE_W = 10;
  localparam int SCALE_W = 4;
  localparam int E1 = 20;
  localparam int X1 = 8;
  localparam int EU = 30;
  localparam int XU = 2;
  localparam int XMIN = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en1, en2, s1_valid, s2_valid, s1_ready, s2_ready;
  logic [CODE_W-1:0] s1_code, tgt1, s2_code, tgt2;
  logic [SCALE_W-1:0] cfg_scale;
  logic pgood1, rst1_n, pgood2, rst2_n;

  power_good_mon #(
    .CODE_W(CODE_W), .CNT_W(32), .SCALE_W(SCALE_W), .ENTRY1_CYC(E1),
    .EXIT1_CYC(X1), .ENTRY2_UNIT(EU), .EXIT2_UNIT(XU), .EXIT_MIN_CYC(XMIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en1(en1), .s1_valid(s1_valid), .s1_ready(s1_ready),
    .s1_code(s1_code), .tgt1(tgt1), .pgood1(pgood1), .rst1_n(rst1_n),
    .en2(en2), .s2_valid(s2_valid), .s2_ready(s2_ready), .s2_code(s2_code),
    .tgt2(tgt2), .cfg_scale(cfg_scale), .pgood2(pgood2), .rst2_n(rst2_n)
  );

  typedef struct {
    int    due;
    int    ch;
    bit    good;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops every scoreboard item that falls due on this cycle.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        chk(q[i].tag, (q[i].ch == 1) ? int'(pgood1) : int'(pgood2), int'(q[i].good));
        chk({q[i].tag, " R5"}, (q[i].ch == 1) ? int'(rst1_n) : int'(rst2_n), int'(q[i].good));
        q.delete(i);
      end
    end
  end

  task automatic push(input int due, input int ch, input bit good, input string tag);
    exp_t e;
    e.due = due; e.ch = ch; e.good = good; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int ch, input int code, input int tgt, output int c0);
    @(negedge clk);
    if (ch == 1) begin
      s1_valid = 1'b1; s1_code = CODE_W'(code); tgt1 = CODE_W'(tgt);
    end else begin
      s2_valid = 1'b1; s2_code = CODE_W'(code); tgt2 = CODE_W'(tgt);
    end
    c0 = cyc;
    @(negedge clk);
    s1_valid = 1'b0;
    s2_valid = 1'b0;
  endtask

  // Transition expected after the (L+1)th qualifying edge: old value at c0+L, new at c0+L+1.
  task automatic expect_edge(input int ch, input int c0, input int lim, input bit rise, input string tag);
    push(c0 + lim, ch, !rise, tag);
    push(c0 + lim + 1, ch, rise, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    int c;
    rst_n = 1'b0; en1 = 1'b1; en2 = 1'b1;
    s1_valid = 1'b0; s2_valid = 1'b0;
    s1_code = '0; s2_code = '0; tgt1 = 10'd500; tgt2 = 10'd500;
    cfg_scale = 4'd1;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R8 reset pgood1", pgood1, 0);
    chk("R8 reset pgood2", pgood2, 0);
    chk("R5 reset rst1_n", rst1_n, 0);
    chk("R9 ready1 follows enable", s1_ready, 1);

    // Channel 1: high boundary sample 471, broken by band sample 470
    send(1, 471, 500, c);
    idle(8);
    send(1, 470, 500, c);
    push(c + 30, 1, 1'b0, "R4 entry restarted by band");
    push(c + 31, 1, 1'b0, "R1 band never enters");
    idle(33);
    send(1, 480, 500, c);
    expect_edge(1, c, E1, 1'b1, "R2 R6 R10 entry ch1");
    idle(25);

    // Band sample 450 keeps good; low sample 449 exits
    send(1, 450, 500, c);
    push(c + 20, 1, 1'b1, "R1 band holds good");
    idle(22);
    send(1, 449, 500, c);
    expect_edge(1, c, X1, 1'b0, "R3 R6 exit ch1");
    idle(12);

    // Exit restarted by a band sample
    send(1, 480, 500, c);
    expect_edge(1, c, E1, 1'b1, "R2 re-entry ch1");
    idle(23);
    send(1, 449, 500, c);
    idle(2);
    send(1, 460, 500, c);
    push(c + 15, 1, 1'b1, "R4 exit restarted by band");
    idle(18);

    // Disable clears, samples refused while disabled
    @(negedge clk);
    en1 = 1'b0;
    push(cyc + 1, 1, 1'b0, "R8 disable drops good");
    idle(1);
    chk("R9 ready1 low when disabled", s1_ready, 0);
    send(1, 480, 500, c);
    idle(30);
    chk("R9 sample ignored when not ready", pgood1, 0);
    en1 = 1'b1;
    idle(30);
    chk("R8 re-enable without sample stays not good", pgood1, 0);

    // Channel 2: scale 1, exit clamped to floor
    cfg_scale = 4'd1;
    send(2, 480, 500, c);
    expect_edge(2, c, EU, 1'b1, "R7 entry scale 1");
    idle(33);
    send(2, 449, 500, c);
    expect_edge(2, c, XMIN, 1'b0, "R7 exit clamped scale 1");
    idle(10);

    // Scale 5, unclamped exit
    cfg_scale = 4'd5;
    send(2, 480, 500, c);
    expect_edge(2, c, 5 * EU, 1'b1, "R7 entry scale 5");
    idle(153);
    send(2, 449, 500, c);
    expect_edge(2, c, 5 * XU, 1'b0, "R7 exit scale 5");
    idle(14);

    // Scale 0 with target 200: immediate entry, floored exit
    cfg_scale = 4'd0;
    send(2, 189, 200, c);
    push(c + 2, 2, 1'b1, "R7 R1 zero-scale entry");
    idle(4);
    send(2, 179, 200, c);
    expect_edge(2, c, XMIN, 1'b0, "R7 R1 zero-scale exit");
    idle(9);
    send(2, 180, 200, c);
    push(c + 10, 2, 1'b0, "R1 band at target 200");
    idle(12);

    while (q.size() != 0) idle(1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule